// File: doc/BRIEF.md
# Mode-Aware Partial-Width Integer Register File

This block holds the general integer registers of an execution core: sixteen 64-bit entries, two combinational read ports and one write port that commits at the clock edge. Every port carries an access width code, so a caller can address the low byte, word, doubleword or the full quadword of an entry. Reads deliver the selected field zero-extended onto a 64-bit bus. Writes merge the new field into the existing register contents.

Which entries and widths an access may use depends on two inputs. `long_mode` selects the 64-bit operating mode. `ext_pfx` reports an extension prefix on the current instruction. Entries 0 to 7 can always be addressed. Entries 8 to 15 and the full 64-bit width both need `long_mode` and `ext_pfx` set together. Any access outside these rules raises `illegal` in the same cycle. An illegal read returns zero and an illegal write is dropped.

Top module: `gpr_file`

## Requirements
- R1: Reset clears every entry, so a legal quadword read of any index after reset returns zero.
- R2: Entries 0 to 7 accept byte, word and doubleword accesses in both modes, whether `ext_pfx` is set or not.
- R3: An access to an entry from 8 to 15 is legal only when both `long_mode` and `ext_pfx` are 1. Otherwise `illegal` is 1, the write is dropped, and that port reads 0.
- R4: Width code 3 (quadword) is legal only when both `long_mode` and `ext_pfx` are 1. Otherwise `illegal` is 1, the write is dropped, and that port reads 0.
- R5: Width codes select a field of the entry: 0 = bits 7:0, 1 = bits 15:0, 2 = bits 31:0, 3 = bits 63:0.
- R6: A byte or word write replaces only its own field and keeps all other bits of the entry.
- R7: A doubleword write clears bits 63:32 when `long_mode` is 1 and keeps bits 63:32 when `long_mode` is 0.
- R8: A legal read drives the selected field on the low bits of its 64-bit bus and drives zeros on the bits above it. A port with its enable low reads 0.
- R9: `illegal` is combinational. It is 1 exactly when at least one enabled port makes an illegal access, and it is 0 when no port is enabled.
- R10: A write becomes visible at the next rising clock edge. A read of the same entry in the same cycle returns the old contents.
- R11: The two read ports work independently. An illegal access on one port does not change the data on the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| long_mode | input | 1 | 1 selects the 64-bit operating mode |
| ext_pfx | input | 1 | Extension prefix present on the current instruction |
| rd0_en | input | 1 | Read port 0 enable |
| rd0_idx | input | 4 | Read port 0 entry index |
| rd0_width | input | 2 | Read port 0 width code |
| rd0_data | output | 64 | Read port 0 zero-extended data |
| rd1_en | input | 1 | Read port 1 enable |
| rd1_idx | input | 4 | Read port 1 entry index |
| rd1_width | input | 2 | Read port 1 width code |
| rd1_data | output | 64 | Read port 1 zero-extended data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write entry index |
| wr_width | input | 2 | Write width code |
| wr_data | input | 64 | Write data; only the selected field is used |
| illegal | output | 1 | Some enabled access breaks the mode, prefix or width rules |

## Verification
The assertions check the legality rules on every cycle. They cover the flag for high entries and for quadword width, the quiet flag when no port is enabled, and zero data on an illegal or narrow read. The merge rules need the bench's scenarios: field preservation on byte and word writes, the mode-dependent doubleword upper half, the suppression of illegal writes, and the old-value result when a read and a write hit the same entry in one cycle. Each of these shows only in what a later read returns, and the bench's reference model tracks that register contents across cycles.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    localparam int XLEN = 64;

    typedef enum logic [1:0] {
        W_BYTE  = 2'd0,
        W_WORD  = 2'd1,
        W_DWORD = 2'd2,
        W_QWORD = 2'd3
    } width_e;

    // Bits of an entry that an access of width w covers
    function automatic logic [XLEN-1:0] field_mask(input width_e w);
        logic [XLEN-1:0] m;
        unique case (w)
            W_BYTE:  m = {{(XLEN-8){1'b0}},  {8{1'b1}}};
            W_WORD:  m = {{(XLEN-16){1'b0}}, {16{1'b1}}};
            W_DWORD: m = {{(XLEN/2){1'b0}},  {(XLEN/2){1'b1}}};
            W_QWORD: m = {XLEN{1'b1}};
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gpr_access_check.sv
module gpr_access_check
    import gpr_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int LEGACY_REGS = 8,
    localparam int IDX_W      = $clog2(NUM_REGS)
) (
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    input  width_e           width,
    input  logic             long_mode,
    input  logic             ext_pfx,
    output logic             legal,
    output logic             fault
);
    localparam logic [IDX_W:0] LEGACY_LIMIT = (IDX_W+1)'(LEGACY_REGS);

    logic wide_ok;
    logic idx_ok;
    logic width_ok;

    // The prefix opens the upper entries and the full width, but only in 64-bit mode
    assign wide_ok  = long_mode && ext_pfx;
    assign idx_ok   = ({1'b0, idx} < LEGACY_LIMIT) || wide_ok;
    assign width_ok = (width != W_QWORD) || wide_ok;
    assign legal    = idx_ok && width_ok;
    assign fault    = en && !legal;
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
    import gpr_pkg::*;
#(
    parameter int NUM_REGS = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [XLEN-1:0]  regs_i [NUM_REGS],
    input  logic             en,
    input  logic             legal,
    input  logic [IDX_W-1:0] idx,
    input  width_e           width,
    output logic [XLEN-1:0]  data
);
    always_comb begin
        if (en && legal) begin
            data = regs_i[idx] & field_mask(width);
        end else begin
            data = '0;
        end
    end
endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge
    import gpr_pkg::*;
(
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] new_val,
    input  width_e          width,
    input  logic            long_mode,
    output logic [XLEN-1:0] merged
);
    always_comb begin
        unique case (width)
            W_BYTE:  merged = {old_val[XLEN-1:8],  new_val[7:0]};
            W_WORD:  merged = {old_val[XLEN-1:16], new_val[15:0]};
            W_DWORD: merged = long_mode ? {{(XLEN/2){1'b0}}, new_val[XLEN/2-1:0]}
                                        : {old_val[XLEN-1:XLEN/2], new_val[XLEN/2-1:0]};
            W_QWORD: merged = new_val;
            default: merged = old_val;
        endcase
    end
endmodule

// File: rtl/gpr_file.sv
module gpr_file
    import gpr_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int LEGACY_REGS = 8,
    localparam int IDX_W      = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             long_mode,
    input  logic             ext_pfx,
    input  logic             rd0_en,
    input  logic [IDX_W-1:0] rd0_idx,
    input  logic [1:0]       rd0_width,
    output logic [XLEN-1:0]  rd0_data,
    input  logic             rd1_en,
    input  logic [IDX_W-1:0] rd1_idx,
    input  logic [1:0]       rd1_width,
    output logic [XLEN-1:0]  rd1_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_width,
    input  logic [XLEN-1:0]  wr_data,
    output logic             illegal
);
    logic [XLEN-1:0] regs_q [NUM_REGS];
    logic [XLEN-1:0] wr_merged;
    logic            rd0_legal, rd0_fault;
    logic            rd1_legal, rd1_fault;
    logic            wr_legal,  wr_fault;
    logic            wr_commit;
    width_e          rd0_w, rd1_w, wr_w;

    assign rd0_w = width_e'(rd0_width);
    assign rd1_w = width_e'(rd1_width);
    assign wr_w  = width_e'(wr_width);

    gpr_access_check #(.NUM_REGS(NUM_REGS), .LEGACY_REGS(LEGACY_REGS)) u_chk_rd0 (
        .en(rd0_en), .idx(rd0_idx), .width(rd0_w), .long_mode(long_mode),
        .ext_pfx(ext_pfx), .legal(rd0_legal), .fault(rd0_fault)
    );
    gpr_access_check #(.NUM_REGS(NUM_REGS), .LEGACY_REGS(LEGACY_REGS)) u_chk_rd1 (
        .en(rd1_en), .idx(rd1_idx), .width(rd1_w), .long_mode(long_mode),
        .ext_pfx(ext_pfx), .legal(rd1_legal), .fault(rd1_fault)
    );
    gpr_access_check #(.NUM_REGS(NUM_REGS), .LEGACY_REGS(LEGACY_REGS)) u_chk_wr (
        .en(wr_en), .idx(wr_idx), .width(wr_w), .long_mode(long_mode),
        .ext_pfx(ext_pfx), .legal(wr_legal), .fault(wr_fault)
    );

    assign illegal   = rd0_fault || rd1_fault || wr_fault;
    assign wr_commit = wr_en && wr_legal;

    gpr_write_merge u_merge (
        .old_val(regs_q[wr_idx]), .new_val(wr_data), .width(wr_w),
        .long_mode(long_mode), .merged(wr_merged)
    );

    // One storage process per entry; only the addressed entry loads
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else if (wr_commit && (wr_idx == IDX_W'(i))) begin
                regs_q[i] <= wr_merged;
            end
        end
    end

    gpr_read_port #(.NUM_REGS(NUM_REGS)) u_rd0 (
        .regs_i(regs_q), .en(rd0_en), .legal(rd0_legal), .idx(rd0_idx),
        .width(rd0_w), .data(rd0_data)
    );
    gpr_read_port #(.NUM_REGS(NUM_REGS)) u_rd1 (
        .regs_i(regs_q), .en(rd1_en), .legal(rd1_legal), .idx(rd1_idx),
        .width(rd1_w), .data(rd1_data)
    );
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
    parameter int IDX_W = 4,
    parameter int XLEN  = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             long_mode,
    input logic             ext_pfx,
    input logic             rd0_en,
    input logic [IDX_W-1:0] rd0_idx,
    input logic [1:0]       rd0_width,
    input logic [XLEN-1:0]  rd0_data,
    input logic             rd1_en,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [1:0]       wr_width,
    input logic             illegal
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd0_en && !rd1_en) |-> !illegal); // R9

    AST_HIGH_IDX_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx[IDX_W-1] && !(long_mode && ext_pfx)) |-> illegal); // R3

    AST_QWORD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_width == 2'd3 && !(long_mode && ext_pfx)) |-> illegal); // R4

    AST_HIGH_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_en && rd0_idx[IDX_W-1] && !ext_pfx) |-> (rd0_data == '0)); // R3

    AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_width == 2'd0) |-> (rd0_data[XLEN-1:8] == '0)); // R8

    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd0_en |-> (rd0_data == '0)); // R8
endmodule

bind gpr_file gpr_file_chk #(.IDX_W(IDX_W), .XLEN(gpr_pkg::XLEN)) u_gpr_file_chk (
    .clk(clk), .rst_n(rst_n), .long_mode(long_mode), .ext_pfx(ext_pfx),
    .rd0_en(rd0_en), .rd0_idx(rd0_idx), .rd0_width(rd0_width), .rd0_data(rd0_data),
    .rd1_en(rd1_en), .wr_en(wr_en), .wr_idx(wr_idx), .wr_width(wr_width),
    .illegal(illegal)
);

// File: tb/tb_gpr_file.sv
module tb_gpr_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        long_mode = 1'b0, ext_pfx = 1'b0;
    logic        rd0_en = 1'b0, rd1_en = 1'b0, wr_en = 1'b0;
    logic [3:0]  rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
    logic [1:0]  rd0_width = '0, rd1_width = '0, wr_width = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd0_data, rd1_data;
    logic        illegal;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [63:0] mdl [16];

    always #4 clk = ~clk;   // 125 MHz

    gpr_file dut (.*);

    function automatic bit ok_access(bit lm, bit px, int idx, int w);
        bit wide = lm && px;
        return (idx < 8 || wide) && (w != 3 || wide);
    endfunction

    function automatic logic [63:0] mask_of(int w);
        if (w == 3) return '1;
        return (64'd1 << (8 << w)) - 64'd1;
    endfunction

    function automatic logic [63:0] exp_read(bit en, bit lm, bit px, int idx, int w);
        if (!en || !ok_access(lm, px, idx, w)) return '0;
        return mdl[idx] & mask_of(w);
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive, compare against the model mid-cycle, update the model at the edge
    task automatic step(string tag, bit lm, bit px,
                        bit we, int wi, int ww, logic [63:0] wd,
                        bit r0e, int r0i, int r0w, bit r1e, int r1i, int r1w);
        bit exp_ill;
        long_mode = lm; ext_pfx = px;
        wr_en = we; wr_idx = 4'(wi); wr_width = 2'(ww); wr_data = wd;
        rd0_en = r0e; rd0_idx = 4'(r0i); rd0_width = 2'(r0w);
        rd1_en = r1e; rd1_idx = 4'(r1i); rd1_width = 2'(r1w);
        #1;
        exp_ill = (we && !ok_access(lm, px, wi, ww)) || (r0e && !ok_access(lm, px, r0i, r0w))
                  || (r1e && !ok_access(lm, px, r1i, r1w));
        check({tag, " rd0"}, rd0_data, exp_read(r0e, lm, px, r0i, r0w));
        check({tag, " rd1"}, rd1_data, exp_read(r1e, lm, px, r1i, r1w));
        check({tag, " illegal"}, {63'd0, illegal}, {63'd0, exp_ill});
        @(posedge clk);
        if (we && ok_access(lm, px, wi, ww)) begin
            logic [63:0] m = mask_of(ww);
            if (ww == 2 && lm) mdl[wi] = wd & m;
            else mdl[wi] = (mdl[wi] & ~m) | (wd & m);
        end
        @(negedge clk);
    endtask

    task automatic wr(string tag, bit lm, bit px, int i, int w, logic [63:0] d);
        step(tag, lm, px, 1, i, w, d, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic rd(string tag, bit lm, bit px, int i0, int w0, int i1, int w1);
        step(tag, lm, px, 0, 0, 0, '0, 1, i0, w0, 1, i1, w1);
    endtask

    initial begin
        #100000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: all entries read zero after reset; R9 idle cycle
        step("R9 idle", 1, 1, 0, 0, 0, '0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 16; i += 2) rd("R1 reset", 1, 1, i, 3, i + 1, 3);
        // R5: full-width loads of every entry
        for (int i = 0; i < 16; i++)
            wr("R5 load", 1, 1, i, 3, {8{8'(8'h11 * i + 8'h0F)}} ^ 64'hA5C3_0000_5A3C_0000);
        for (int i = 0; i < 16; i += 2) rd("R5 readback", 1, 1, i, 3, i + 1, 3);
        // R6: byte and word merges
        wr("R6 byte", 0, 0, 3, 0, 64'hFFFF_FFFF_FFFF_FF77);
        wr("R6 word", 1, 0, 5, 1, 64'h1234_5678_9ABC_BEEF);
        rd("R6 check", 1, 1, 3, 3, 5, 3);
        // R7: doubleword upper half depends on mode
        wr("R7 long dword", 1, 0, 2, 2, 64'hDEAD_BEEF_CAFE_F00D);
        wr("R7 legacy dword", 0, 0, 4, 2, 64'hDEAD_BEEF_0BAD_F00D);
        rd("R7 check", 1, 1, 2, 3, 4, 3);
        // R2: low entries in legacy mode, each width but quadword
        for (int w = 0; w < 3; w++) rd("R2 legacy", 0, 0, 6, w, 7, w);
        rd("R2 prefix legacy", 0, 1, 1, 2, 0, 1);
        // R3: upper entries blocked without both controls
        wr("R3 legacy hi", 0, 1, 9, 0, 64'h55);
        wr("R3 noprefix hi", 1, 0, 12, 2, 64'h0123_4567);
        rd("R3 hi read", 1, 0, 9, 0, 12, 2);
        rd("R3 verify", 1, 1, 9, 3, 12, 3);
        // R4: quadword blocked without both controls
        wr("R4 legacy q", 0, 1, 1, 3, 64'hFEED_FACE_0000_1111);
        wr("R4 noprefix q", 1, 0, 0, 3, 64'hFEED_FACE_0000_2222);
        rd("R4 verify", 1, 1, 1, 3, 0, 3);
        // R8: narrow reads zero-extend
        rd("R8 zext", 1, 1, 14, 0, 15, 1);
        rd("R8 zext dword", 1, 1, 13, 2, 11, 0);
        step("R8 disabled", 1, 1, 0, 0, 0, '0, 0, 4, 3, 1, 4, 3);
        // R10: same-cycle read sees old value
        step("R10 rw same", 1, 1, 1, 8, 3, 64'h0F0F_0F0F_0F0F_0F0F, 1, 8, 3, 1, 8, 0);
        rd("R10 after", 1, 1, 8, 3, 8, 1);
        // R11: one port illegal, the other legal
        rd("R11 split", 1, 0, 10, 1, 7, 3 - 1);
        rd("R11 split b", 0, 0, 2, 1, 3, 3);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule